// File: doc/BRIEF.md
# Transfer-Record Register Access Gate

This block decides, in a single combinational step, what happens to each software access that touches the control-transfer record registers or executes the record-clear instruction. The pipeline presents a request with four pieces of information: the current privilege level, whether the hart runs virtualised, the machine-level and hypervisor-level state-enable bits for the feature, and which target is being accessed. The block answers with exactly one verdict: the access proceeds, it raises illegal-instruction, or it raises virtual-instruction.

Two further outputs shape the accesses that proceed. The first redirects a virtualised supervisor access to the control register onto the guest's private copy. The second tells the register file to present the machine-only control fields as read-only zero for any access made below machine mode.

The state-enable bits only guard this register interface. The recorder keeps capturing transfers whatever their state, so nothing in this block feeds the capture path. Storage and trap delivery are outside the block.

Top module: `ctrgate_top`

## Requirements
- R1: With `req_valid_i` low, `allow_o`, `illegal_o`, `virtual_o`, `guest_sel_o` and `mfield_ro0_o` are all low.
- R2: At machine privilege (`priv_i` = 3), every defined target is allowed, whatever the values of `virt_i`, `m_en_i` and `h_en_i`.
- R3: Below machine mode with `m_en_i` low, every defined target raises illegal-instruction. The defined targets are 0 control, 1 depth, 2 status, 3 entry window and 4 clear. The privilege codes are 0 user and 1 supervisor.
- R4: The machine-level check wins. In virtualised supervisor mode with both enables low, the verdict is illegal-instruction, not virtual-instruction.
- R5: In virtualised supervisor mode with `m_en_i` high and `h_en_i` low, every defined target raises virtual-instruction.
- R6: A depth access (target 1) from virtualised supervisor mode raises virtual-instruction even when both enables are high.
- R7: With `m_en_i` high, non-virtualised user mode raises illegal-instruction for every defined target, including clear. Virtualised user mode raises virtual-instruction for every defined target.
- R8: `guest_sel_o` is high exactly when a control access (target 0) is allowed from virtualised supervisor mode.
- R9: `mfield_ro0_o` is high exactly when a control access is allowed below machine mode.
- R10: A valid request yields exactly one of `allow_o`, `illegal_o` and `virtual_o`. The reserved privilege code 2 and the undefined target codes 5 to 7 always give illegal-instruction.
- R11: When `virt_i` is low, or at machine privilege, the verdict and both select outputs do not depend on `h_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid_i | input | 1 | An access is being decided this cycle |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine, 2 reserved |
| virt_i | input | 1 | Hart runs in virtualised (guest) mode |
| m_en_i | input | 1 | Machine-level state-enable bit for the feature |
| h_en_i | input | 1 | Hypervisor-level state-enable bit for the feature |
| target_i | input | 3 | Access target: 0 control, 1 depth, 2 status, 3 entry window, 4 clear |
| allow_o | output | 1 | Access proceeds |
| illegal_o | output | 1 | Raise illegal-instruction |
| virtual_o | output | 1 | Raise virtual-instruction |
| guest_sel_o | output | 1 | Route the control access to the guest copy |
| mfield_ro0_o | output | 1 | Present the machine-only control fields as read-only zero |

## Verification
The checker watches several properties on every input change:
- the verdict is one-hot, and a valid request always gets a verdict;
- machine-mode accesses always proceed;
- a cleared machine-level enable below machine mode always faults as illegal;
- virtualised depth accesses never proceed;
- both select outputs only accompany an allowed access in the right mode.

Two matters can only be shown by the bench, which compares the outputs against its own rule table over random and directed patterns. The first is the full priority order between the machine and hypervisor checks. The second is the independence of non-virtualised verdicts from the hypervisor enable, which the bench shows by flipping that bit between otherwise identical requests.

// File: rtl/ctrgate_pkg.sv
package ctrgate_pkg;

  localparam int PRIV_W = 2;
  localparam int TGT_W  = 3;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [TGT_W-1:0] {
    TGT_CTL    = 3'd0,
    TGT_DEPTH  = 3'd1,
    TGT_STATUS = 3'd2,
    TGT_ENTRY  = 3'd3,
    TGT_CLEAR  = 3'd4
  } target_e;

  localparam int NUM_TARGETS = 5;

  // Target code names one of the gated registers or the clear instruction
  function automatic logic target_known(input logic [TGT_W-1:0] t);
    return (int'(t) < NUM_TARGETS);
  endfunction

  // Privilege is user or supervisor (a defined level under machine)
  function automatic logic priv_low(input logic [PRIV_W-1:0] p);
    return (p == PRIV_USER) || (p == PRIV_SUPER);
  endfunction

endpackage

// File: rtl/ctrgate_mstage.sv
// Machine-level stage: encoding faults and the machine state-enable gate.
module ctrgate_mstage
  import ctrgate_pkg::*;
(
  input  logic              valid_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic              m_en_i,
  output logic              is_mach_o,
  output logic              code_fault_o,
  output logic              m_fault_o
);

  logic known_tgt;
  logic below_m;

  always_comb begin
    known_tgt    = target_known(target_i);
    below_m      = priv_low(priv_i);
    is_mach_o    = valid_i && (priv_i == PRIV_MACH) && known_tgt;
    code_fault_o = valid_i && (!known_tgt || (priv_i == PRIV_RSVD));
    m_fault_o    = valid_i && known_tgt && below_m && !m_en_i;
  end

endmodule

// File: rtl/ctrgate_hstage.sv
// Privilege and hypervisor stage: faults that apply once the machine gate passes.
module ctrgate_hstage
  import ctrgate_pkg::*;
(
  input  logic              valid_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              virt_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic              h_en_i,
  output logic              u_fault_o,
  output logic              v_fault_o
);

  logic known_tgt;
  logic is_user;
  logic is_vs;

  always_comb begin
    known_tgt = target_known(target_i);
    is_user   = (priv_i == PRIV_USER);
    is_vs     = (priv_i == PRIV_SUPER) && virt_i;
    // Host user mode has no access to supervisor-level registers nor the clear
    u_fault_o = valid_i && known_tgt && is_user && !virt_i;
    // Guest user mode, a disabled guest gate, or the always-trapped depth register
    v_fault_o = valid_i && known_tgt &&
                ((is_user && virt_i) ||
                 (is_vs && (!h_en_i || (target_i == TGT_DEPTH))));
  end

endmodule

// File: rtl/ctrgate_view.sv
// View selection for allowed control-register accesses.
module ctrgate_view
  import ctrgate_pkg::*;
(
  input  logic              allow_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              virt_i,
  input  logic [TGT_W-1:0]  target_i,
  output logic              guest_sel_o,
  output logic              ro0_o
);

  logic ctl_hit;

  always_comb begin
    ctl_hit     = allow_i && (target_i == TGT_CTL);
    guest_sel_o = ctl_hit && (priv_i == PRIV_SUPER) && virt_i;
    ro0_o       = ctl_hit && (priv_i != PRIV_MACH);
  end

endmodule

// File: rtl/ctrgate_top.sv
module ctrgate_top
  import ctrgate_pkg::*;
(
  input  logic              req_valid_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              virt_i,
  input  logic              m_en_i,
  input  logic              h_en_i,
  input  logic [TGT_W-1:0]  target_i,
  output logic              allow_o,
  output logic              illegal_o,
  output logic              virtual_o,
  output logic              guest_sel_o,
  output logic              mfield_ro0_o
);

  // Named internal events, visible to the bound checker
  logic is_mach;
  logic code_fault;
  logic m_fault;
  logic u_fault;
  logic v_fault;
  logic allow_int;

  ctrgate_mstage u_mstage (
    .valid_i      (req_valid_i),
    .priv_i       (priv_i),
    .target_i     (target_i),
    .m_en_i       (m_en_i),
    .is_mach_o    (is_mach),
    .code_fault_o (code_fault),
    .m_fault_o    (m_fault)
  );

  ctrgate_hstage u_hstage (
    .valid_i   (req_valid_i),
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .target_i  (target_i),
    .h_en_i    (h_en_i),
    .u_fault_o (u_fault),
    .v_fault_o (v_fault)
  );

  // Priority: encoding / machine-level / host-user faults before guest faults
  always_comb begin
    illegal_o = code_fault || m_fault || u_fault;
    virtual_o = !illegal_o && v_fault;
    allow_int = req_valid_i && !illegal_o && !virtual_o &&
                (is_mach || priv_low(priv_i));
    allow_o   = allow_int;
  end

  ctrgate_view u_view (
    .allow_i     (allow_int),
    .priv_i      (priv_i),
    .virt_i      (virt_i),
    .target_i    (target_i),
    .guest_sel_o (guest_sel_o),
    .ro0_o       (mfield_ro0_o)
  );

endmodule

// File: rtl/ctrgate_chk.sv
module ctrgate_chk
  import ctrgate_pkg::*;
(
  input logic              req_valid_i,
  input logic [PRIV_W-1:0] priv_i,
  input logic              virt_i,
  input logic              m_en_i,
  input logic [TGT_W-1:0]  target_i,
  input logic              allow_o,
  input logic              illegal_o,
  input logic              virtual_o,
  input logic              guest_sel_o,
  input logic              mfield_ro0_o
);

  always_comb begin
    // R1
    idle_quiet_chk: assert (req_valid_i ||
      !(allow_o || illegal_o || virtual_o || guest_sel_o || mfield_ro0_o));
    // R10
    one_verdict_chk: assert (!req_valid_i ||
      $countones({allow_o, illegal_o, virtual_o}) == 1);
    // R2
    mach_allow_chk: assert (!(req_valid_i && priv_i == PRIV_MACH &&
      target_known(target_i)) || allow_o);
    // R3
    mgate_illegal_chk: assert (!(req_valid_i && priv_low(priv_i) &&
      !m_en_i && target_known(target_i)) || illegal_o);
    // R6
    vs_depth_chk: assert (!(req_valid_i && priv_i == PRIV_SUPER && virt_i &&
      target_i == TGT_DEPTH) || !allow_o);
    // R8
    guest_sel_chk: assert (!guest_sel_o ||
      (allow_o && virt_i && priv_i == PRIV_SUPER));
    // R9
    ro0_chk: assert (!mfield_ro0_o || (allow_o && priv_i != PRIV_MACH));
  end

endmodule

bind ctrgate_top ctrgate_chk u_chk (
  .req_valid_i  (req_valid_i),
  .priv_i       (priv_i),
  .virt_i       (virt_i),
  .m_en_i       (m_en_i),
  .target_i     (target_i),
  .allow_o      (allow_o),
  .illegal_o    (illegal_o),
  .virtual_o    (virtual_o),
  .guest_sel_o  (guest_sel_o),
  .mfield_ro0_o (mfield_ro0_o)
);

// File: tb/ctrgate_top_tb_top.sv
module ctrgate_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       req_valid, virt, m_en, h_en;
  logic [1:0] priv;
  logic [2:0] target;
  logic       allow, illegal, virt_exc, gsel, ro0;

  int checks = 0;
  int errors = 0;

  ctrgate_top dut_i (
    .req_valid_i  (req_valid),
    .priv_i       (priv),
    .virt_i       (virt),
    .m_en_i       (m_en),
    .h_en_i       (h_en),
    .target_i     (target),
    .allow_o      (allow),
    .illegal_o    (illegal),
    .virtual_o    (virt_exc),
    .guest_sel_o  (gsel),
    .mfield_ro0_o (ro0)
  );

  // Expected outputs packed {allow, illegal, virtual, guest_sel, ro0}
  function automatic logic [4:0] model(input logic v, input logic [1:0] p,
      input logic vi, input logic me, input logic he, input logic [2:0] t);
    logic a, il, vx;
    a = 0; il = 0; vx = 0;
    if (!v) return 5'b0;
    if (t > 3'd4 || p == 2'd2) il = 1;          // R10
    else if (p == 2'd3) a = 1;                  // R2
    else if (!me) il = 1;                       // R3, R4
    else if (p == 2'd0) begin                   // R7
      if (vi) vx = 1; else il = 1;
    end else if (vi && (!he || t == 3'd1)) vx = 1; // R5, R6
    else a = 1;
    return {a, il, vx, a && t == 3'd0 && vi && p == 2'd1,
            a && t == 3'd0 && p != 2'd3};       // R8, R9
  endfunction

  task automatic apply(input logic v, input logic [1:0] p, input logic vi,
      input logic me, input logic he, input logic [2:0] t);
    @(negedge clk);
    req_valid = v; priv = p; virt = vi; m_en = me; h_en = he; target = t;
    #1;
  endtask

  task automatic check(input string req);
    logic [4:0] exp, act;
    exp = model(req_valid, priv, virt, m_en, h_en, target);
    act = {allow, illegal, virt_exc, gsel, ro0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: p=%0d v=%0b me=%0b he=%0b t=%0d act=%b exp=%b",
               req, priv, virt, m_en, h_en, target, act, exp);
    end
  endtask

  initial begin
    req_valid = 0; priv = 0; virt = 0; m_en = 0; h_en = 0; target = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(0, 2'd1, 1, 1, 1, 3'd0); check("R1 idle");
    apply(1, 2'd3, 1, 0, 0, 3'd1); check("R2 machine no enables");
    apply(1, 2'd3, 0, 1, 1, 3'd0); check("R2 machine control");
    apply(1, 2'd1, 0, 0, 1, 3'd3); check("R3 S entry m_en low");
    apply(1, 2'd0, 0, 0, 0, 3'd4); check("R3 U clear m_en low");
    apply(1, 2'd1, 1, 0, 0, 3'd2); check("R4 machine priority");
    apply(1, 2'd1, 1, 1, 0, 3'd2); check("R5 VS status h_en low");
    apply(1, 2'd1, 1, 1, 1, 3'd1); check("R6 VS depth all enables");
    apply(1, 2'd0, 0, 1, 1, 3'd4); check("R7 U clear");
    apply(1, 2'd0, 1, 1, 1, 3'd4); check("R7 VU clear");
    apply(1, 2'd1, 1, 1, 1, 3'd0); check("R8 VS control guest copy");
    apply(1, 2'd1, 0, 1, 0, 3'd0); check("R9 S control ro0");
    apply(1, 2'd2, 0, 1, 1, 3'd0); check("R10 reserved priv");
    apply(1, 2'd3, 0, 1, 1, 3'd6); check("R10 undefined target");
    // R11: flip h_en on non-virtual requests
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 5; t++) begin
        apply(1, 2'(p), 0, 1, 0, 3'(t)); check("R11 h_en low");
        apply(1, 2'(p), 0, 1, 1, 3'(t)); check("R11 h_en high");
      end
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[0] | r[1], r[3:2], r[4], r[5] | r[6], r[7], 3'(r[10:8] % 3'd6));
      check("R10 random mix");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule